// File: doc/BRIEF.md
# Searchable Writeback Queue

This block is a small first-in first-out queue for the records that leave an execute stage and wait for their writeback. Each record carries a two-bit kind, a destination register index and a data word. Besides the usual push, pop, head view and flush, the queue has two independent lookup ports. Each port takes a register index and reports at once whether any record still waiting in the queue will write that register. An issue stage uses one port for each source operand of an instruction, so a read-after-write hazard on either operand can be found in a single cycle.

Within one cycle the queue acts in a fixed order: pop, then lookup, then push, then flush. A lookup therefore ignores the head record when that record is popped in the same cycle, and it does not yet see a record pushed in that cycle. Flush empties the queue and wins over a push or pop in the same cycle. The depth is a parameter. At depth 2 and above, a push is accepted whenever the queue is not full. At depth 1, a push may also be accepted in the same cycle as a pop of the single held record.

Top module: `wb_search_queue`

## Requirements
- R1: After reset the queue is empty: `can_pop` is 0, `can_push` is 1, and both lookup ports return 0.
- R2: Records leave in the order they were accepted, with kind, destination and data unchanged. No record is lost or duplicated.
- R3: With DEPTH of 2 or more, `can_push` is 0 while DEPTH records are held, and a push made while `can_push` is 0 is ignored.
- R4: A pop made while `can_pop` is 0 is ignored. `can_pop` is 1 exactly when at least one record is held.
- R5: Kind encoding: 2'b00 is an ALU result, 2'b01 is a load, 2'b10 is a store and 2'b11 is a host-register write. A lookup hits only on held ALU or load records whose destination equals the lookup index. Store and host records never hit, whatever their destination field holds.
- R6: The two lookup ports work independently in the same cycle, each with its own index and result.
- R7: A lookup does not see the head record when that record is popped in the same cycle, and it does not see a record pushed in the same cycle.
- R8: Flush empties the queue on the next edge and overrides a same-cycle push or pop. A lookup made during the flush cycle still sees the held records.
- R9: With DEPTH of 2 or more and one record held, a push and a pop in the same cycle both take effect, so one record (the new one) is held afterwards.
- R10: With DEPTH of 1 and the queue full, `can_push` is 0 when no pop is requested and 1 when a pop is requested in the same cycle. A push made together with that pop replaces the held record.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push | input | 1 | Request to append a record |
| push_kind | input | 2 | Kind of the record to append |
| push_dest | input | IDX_W | Destination register index of the record to append |
| push_data | input | DATA_W | Data word of the record to append |
| can_push | output | 1 | A push is accepted this cycle |
| pop | input | 1 | Request to remove the head record |
| can_pop | output | 1 | The queue holds at least one record |
| head_kind | output | 2 | Kind of the head record |
| head_dest | output | IDX_W | Destination of the head record |
| head_data | output | DATA_W | Data of the head record |
| flush | input | 1 | Empty the queue |
| find_a_idx | input | IDX_W | Lookup index, port A |
| find_a_hit | output | 1 | Port A matched a held record |
| find_b_idx | input | IDX_W | Lookup index, port B |
| find_b_hit | output | 1 | Port B matched a held record |

## Verification
The lookups are tried against held records of all four kinds that share the same destination index. This shows whether the kind filter is used or only the index is compared. Lookups are made in cycles that also pop the head, push a new record or flush. These patterns show whether the lookup sees the queue before or after each same-cycle change. A long stretch of mixed random pushes, pops, flushes and lookups is compared against an ordered model. That run shows lost, repeated or reordered records, and it shows when the two ports interfere with each other. A separate depth-1 instance checks that a push is allowed only when a pop frees the single slot in the same cycle.

// File: rtl/wb_search_queue.sv
module wb_search_queue #(
  parameter int DEPTH  = 2,
  parameter int IDX_W  = 5,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [1:0]        push_kind,
  input  logic [IDX_W-1:0]  push_dest,
  input  logic [DATA_W-1:0] push_data,
  output logic              can_push,
  input  logic              pop,
  output logic              can_pop,
  output logic [1:0]        head_kind,
  output logic [IDX_W-1:0]  head_dest,
  output logic [DATA_W-1:0] head_data,
  input  logic              flush,
  input  logic [IDX_W-1:0]  find_a_idx,
  output logic              find_a_hit,
  input  logic [IDX_W-1:0]  find_b_idx,
  output logic              find_b_hit
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [1:0] K_ALU  = 2'b00;
  localparam logic [1:0] K_LOAD = 2'b01;

  logic [1:0]        kind_q [DEPTH];
  logic [IDX_W-1:0]  dest_q [DEPTH];
  logic [DATA_W-1:0] data_q [DEPTH];
  logic [DEPTH-1:0]  vld;
  logic [DEPTH-1:0]  live;
  logic [PW-1:0]     rd_ptr, wr_ptr;
  logic              pop_fire, push_fire;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign can_pop = |vld;

  generate
    if (DEPTH == 1) begin : g_single
      assign can_push = !(&vld) || pop;
    end else begin : g_multi
      assign can_push = !(&vld);
    end
  endgenerate

  assign pop_fire  = pop && can_pop;
  assign push_fire = push && can_push;

  assign head_kind = kind_q[rd_ptr];
  assign head_dest = dest_q[rd_ptr];
  assign head_data = data_q[rd_ptr];

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_live
      assign live[g] = vld[g] && !(pop_fire && rd_ptr == PW'(g))
                       && (kind_q[g] == K_ALU || kind_q[g] == K_LOAD);
    end
  endgenerate

  always_comb begin
    find_a_hit = 1'b0;
    find_b_hit = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (live[i] && dest_q[i] == find_a_idx) find_a_hit = 1'b1;
      if (live[i] && dest_q[i] == find_b_idx) find_b_hit = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld    <= '0;
      rd_ptr <= '0;
      wr_ptr <= '0;
    end else if (flush) begin
      vld    <= '0;
      rd_ptr <= '0;
      wr_ptr <= '0;
    end else begin
      if (pop_fire) begin
        vld[rd_ptr] <= 1'b0;
        rd_ptr      <= bump(rd_ptr);
      end
      if (push_fire) begin
        vld[wr_ptr] <= 1'b1;
        wr_ptr      <= bump(wr_ptr);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (push_fire) begin
      kind_q[wr_ptr] <= push_kind;
      dest_q[wr_ptr] <= push_dest;
      data_q[wr_ptr] <= push_data;
    end
  end

  a_r8_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !can_pop);

  a_r5_empty_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
    !can_pop |-> (!find_a_hit && !find_b_hit));

  a_r2_head_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (can_pop && !pop && !flush) |=>
      (can_pop && $stable(head_kind) && $stable(head_dest) && $stable(head_data)));

  a_r3_push_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (push && can_push && !flush) |=> can_pop);

  a_r4_last_pop_empties: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(vld) == 1 && pop && !push && !flush) |=> !can_pop);
endmodule

// File: tb/sim_wb_search_queue.sv
module sim_wb_search_queue;
  typedef struct packed {
    logic [1:0]  kind;
    logic [4:0]  dest;
    logic [31:0] data;
  } rec_t;

  logic clk = 0;
  logic rst_n = 0;
  always #5 clk = ~clk;

  logic        push = 0, pop = 0, flush = 0;
  logic [1:0]  push_kind = 0;
  logic [4:0]  push_dest = 0, fa = 0, fb = 0;
  logic [31:0] push_data = 0;
  logic        can_push, can_pop, hit_a, hit_b;
  logic [1:0]  head_kind;
  logic [4:0]  head_dest;
  logic [31:0] head_data;

  logic        s_push = 0, s_pop = 0, s_flush = 0;
  logic [1:0]  s_kind = 0;
  logic [4:0]  s_dest = 0, s_fa = 0, s_fb = 0;
  logic [31:0] s_data = 0;
  logic        s_can_push, s_can_pop, s_hit_a, s_hit_b;
  logic [1:0]  s_head_kind;
  logic [4:0]  s_head_dest;
  logic [31:0] s_head_data;

  int checks = 0, fails = 0;
  bit done = 0;
  rec_t exp_q[$];
  bit   m_pf;
  rec_t m_front;

  wb_search_queue #(.DEPTH(2), .IDX_W(5), .DATA_W(32)) u0 (
    .clk(clk), .rst_n(rst_n), .push(push), .push_kind(push_kind),
    .push_dest(push_dest), .push_data(push_data), .can_push(can_push),
    .pop(pop), .can_pop(can_pop), .head_kind(head_kind), .head_dest(head_dest),
    .head_data(head_data), .flush(flush), .find_a_idx(fa), .find_a_hit(hit_a),
    .find_b_idx(fb), .find_b_hit(hit_b));

  wb_search_queue #(.DEPTH(1), .IDX_W(5), .DATA_W(32)) u1 (
    .clk(clk), .rst_n(rst_n), .push(s_push), .push_kind(s_kind),
    .push_dest(s_dest), .push_data(s_data), .can_push(s_can_push),
    .pop(s_pop), .can_pop(s_can_pop), .head_kind(s_head_kind), .head_dest(s_head_dest),
    .head_data(s_head_data), .flush(s_flush), .find_a_idx(s_fa), .find_a_hit(s_hit_a),
    .find_b_idx(s_fb), .find_b_hit(s_hit_b));

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit model_hit(input logic [4:0] idx, input bit skip_head);
    for (int i = 0; i < exp_q.size(); i++)
      if (!(skip_head && i == 0) && exp_q[i].kind < 2 && exp_q[i].dest == idx) return 1;
    return 0;
  endfunction

  task automatic cyc(input bit pu, input logic [1:0] k, input logic [4:0] d,
                     input logic [31:0] v, input bit po, input bit fl,
                     input logic [4:0] sa, input logic [4:0] sb);
    @(negedge clk);
    push = pu; push_kind = k; push_dest = d; push_data = v;
    pop = po; flush = fl; fa = sa; fb = sb;
  endtask

  // Scoreboard monitor: the model tracks R2 order, R4 occupancy, R5 R6 R7 lookups
  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      m_pf = pop && (exp_q.size() != 0);
      chk(can_pop == (exp_q.size() != 0), "R4 occupancy", can_pop, exp_q.size() != 0);
      chk(hit_a == model_hit(fa, m_pf), "R5 R6 R7 port A", hit_a, model_hit(fa, m_pf));
      chk(hit_b == model_hit(fb, m_pf), "R5 R6 R7 port B", hit_b, model_hit(fb, m_pf));
      if (pop && can_pop) begin
        if (exp_q.size() == 0) chk(0, "R2 pop with empty model", 1, 0);
        else begin
          m_front = exp_q.pop_front();
          chk({head_kind, head_dest, head_data} == m_front, "R2 head record",
              {head_kind, head_dest, head_data}, m_front);
        end
      end
      if (push && can_push) exp_q.push_back('{kind: push_kind, dest: push_dest, data: push_data});
      if (flush) exp_q.delete();
    end
  end

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #2;
    chk(can_pop == 0, "R1 can_pop", can_pop, 0);
    chk(can_push == 1, "R1 can_push", can_push, 1);
    chk(!hit_a && !hit_b, "R1 lookups", {hit_a, hit_b}, 0);
    chk(s_can_push == 1 && s_can_pop == 0, "R1 depth1", {s_can_push, s_can_pop}, 2);
    @(negedge clk); rst_n = 1;

    cyc(1, 2'b00, 5'd3, 32'hA0A0_0001, 0, 0, 5'd3, 5'd4);   // R7 push not yet visible
    cyc(1, 2'b10, 5'd4, 32'h0000_0002, 0, 0, 5'd3, 5'd4);   // store with dest 4
    cyc(1, 2'b01, 5'd9, 32'h0000_0003, 0, 0, 5'd3, 5'd4);   // full: ignored
    #2; chk(can_push == 0, "R3 full blocks push", can_push, 0);
    cyc(0, 2'b00, 5'd0, 32'h0, 0, 0, 5'd9, 5'd4);            // R3 dropped load invisible
    cyc(0, 2'b00, 5'd0, 32'h0, 1, 0, 5'd3, 5'd3);            // R7 popped head excluded
    cyc(1, 2'b01, 5'd7, 32'h0000_0004, 1, 0, 5'd7, 5'd4);    // R9 push+pop with one held
    cyc(0, 2'b00, 5'd0, 32'h0, 0, 0, 5'd7, 5'd1);
    #2; chk(can_pop == 1 && can_push == 1, "R9 one record left", {can_pop, can_push}, 3);
    cyc(1, 2'b11, 5'd7, 32'hC0DE_0005, 0, 0, 5'd7, 5'd7);    // host write, dest 7
    cyc(1, 2'b00, 5'd1, 32'h0000_0006, 0, 1, 5'd7, 5'd1);    // R8 flush beats push
    cyc(0, 2'b00, 5'd0, 32'h0, 1, 0, 5'd7, 5'd1);            // R4 pop on empty
    #2; chk(can_pop == 0, "R8 flushed", can_pop, 0);
    cyc(1, 2'b00, 5'd1, 32'h0000_0007, 0, 0, 5'd1, 5'd1);
    cyc(0, 2'b00, 5'd0, 32'h0, 0, 0, 5'd1, 5'd2);
    #2; chk(hit_a && !hit_b, "R6 independent ports", {hit_a, hit_b}, 2);
    cyc(0, 2'b00, 5'd0, 32'h0, 1, 0, 5'd1, 5'd1);

    for (int n = 0; n < 400; n++) begin
      logic [31:0] r;
      r = $urandom;
      cyc(r[0], r[2:1], {2'b00, r[5:3]}, $urandom, r[7:6] != 2'b00, r[13:8] == 6'd0,
          {2'b00, r[16:14]}, {2'b00, r[19:17]});
    end
    cyc(0, 2'b00, 5'd0, 32'h0, 1, 0, 5'd0, 5'd0);
    cyc(0, 2'b00, 5'd0, 32'h0, 1, 0, 5'd0, 5'd0);
    cyc(0, 2'b00, 5'd0, 32'h0, 0, 0, 5'd0, 5'd0);
    #2; chk(can_pop == 0 && exp_q.size() == 0, "R2 drained", can_pop, 0);

    @(negedge clk); s_push = 1; s_kind = 2'b00; s_dest = 5'd2; s_data = 32'h1111_0001;
    @(negedge clk); s_push = 0;
    #2; chk(s_can_push == 0, "R10 full no pop", s_can_push, 0);
    s_pop = 1; s_push = 1; s_data = 32'h2222_0002; s_dest = 5'd6;
    #1; chk(s_can_push == 1, "R10 pop frees slot", s_can_push, 1);
    @(negedge clk); s_pop = 0; s_push = 0;
    #2; chk(s_can_pop == 1 && s_head_data == 32'h2222_0002, "R10 replaced record",
            s_head_data, 32'h2222_0002);
    s_fa = 5'd6; s_fb = 5'd2;
    #1; chk(s_hit_a && !s_hit_b, "R10 R5 depth1 lookup", {s_hit_a, s_hit_b}, 2);
    @(negedge clk); s_pop = 1;
    @(negedge clk); s_pop = 0;
    #2; chk(s_can_pop == 0, "R10 drained", s_can_pop, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule